// File: doc/BRIEF.md
# Receive Frame Address and Error Classifier

This block watches a received frame as it arrives one byte per cycle, after the preamble has been stripped off. It judges the destination address against a programmed 48-bit station address and detects group (multicast) and all-ones (broadcast) destinations. It also counts the frame length and collects the error indications that arrive at end of carrier: the CRC verdict and the count of leftover bits. When the frame ends, it decides from a 4-bit accept mode whether the frame is kept. It also forms the 16-bit status word that the buffer logic writes ahead of the frame bytes. A frame that is not kept leaves its buffer free, so the buffer logic can reuse that buffer for the next frame.

The controller is a four-state machine:
- `S_IDLE` waits for `frame_start`.
- `S_ADDR` compares the first six bytes serially. It moves to `S_BODY` once the sixth byte has been taken in, or to `S_REPORT` on `frame_end`.
- `S_BODY` counts the remaining bytes and moves to `S_REPORT` on `frame_end`.
- `S_REPORT` holds the decision for one cycle. It then returns to `S_IDLE`, or goes straight to `S_ADDR` if a new `frame_start` arrives.

A `frame_start` seen in `S_ADDR` or `S_BODY` abandons the current frame and restarts the comparison.

Top module: `rx_frame_filter`

## Requirements
- R1: Status bit 12 is an active-low address match. It is 0 only if all six destination bytes equal the station address. The first received byte is compared with `station_addr[47:40]`, and the sixth with `station_addr[7:0]`.
- R2: Status bit 14 is an active-low broadcast flag. It is 0 only if all six destination bytes are 8'hFF.
- R3: Status bit 13 flags a range error. It is 1 when the byte count, including the 4 CRC bytes, is below 64 or above 1518.
- R4: Status bit 15 copies `fcs_bad` as seen with `frame_end`. Status bit 11 is 1 when `extra_bits` (received bit count modulo 8) is nonzero at `frame_end`.
- R5: Status bits 10:0 give the byte offset just past the frame in the buffer. This is the frame byte count plus 2 header bytes, saturating at 2047.
- R6: Modes 0, 1 and 2 accept every destination address.
- R7: Modes 3, 4 and 5 accept a matching address or any group address. A group address is one with bit 0 of the first byte set, and this includes broadcast.
- R8: Modes 6, 7 and 8 accept only a matching address or broadcast. A group address that is not broadcast is rejected.
- R9: The error filter depends on the mode modulo 3. A remainder of 0 applies no filter. A remainder of 1 rejects any range, CRC or framing error. A remainder of 2 rejects only CRC or framing errors, so a range error alone is still kept.
- R10: Modes 9 to 15 reject every frame.
- R11: After reset, `done`, `keep` and `status` are 0. `done` is a single-cycle pulse in the cycle after `frame_end` is sampled, and `keep` and `status` are valid while it is high.
- R12: A frame with fewer than six bytes never matches and is never broadcast, so bits 12 and 14 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| station_addr | input | 48 | Station address; bits 47:40 are the first byte on the wire |
| accept_mode | input | 4 | Accept mode, sampled with `frame_end` |
| frame_start | input | 1 | Pulse marking the start of a frame |
| byte_valid | input | 1 | A frame byte is present on `byte_data` |
| byte_data | input | 8 | Frame byte |
| frame_end | input | 1 | Pulse at end of carrier, never in the same cycle as a byte |
| extra_bits | input | 3 | Received bit count modulo 8, valid with `frame_end` |
| fcs_bad | input | 1 | CRC check failed, valid with `frame_end` |
| done | output | 1 | Decision pulse |
| keep | output | 1 | Frame is kept |
| status | output | 16 | Status header word |

## Verification
A comparator that slips by one byte, or an address flag that does not clear between frames, gives wrong values in status bits 12 and 14. This shows in the first `done` pulse after the faulty frame, one cycle after `frame_end`. A length counter that fails to saturate or to clear shows as a wrong offset in bits 10:0 and a wrong range bit, again within that one pulse. A wrong mode decode appears only as a wrong `keep`. The bench therefore crosses every mode class with every address class and with each kind of error.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ADDR   = 2'd1,
        S_BODY   = 2'd2,
        S_REPORT = 2'd3
    } rxf_state_t;

    typedef struct packed {
        logic        crc_err;
        logic        bcast_n;
        logic        range_err;
        logic        match_n;
        logic        frame_err;
        logic [10:0] offset;
    } rxf_status_t;
endpackage

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    byte_en,
    input  logic [7:0]              byte_data,
    input  logic [ADDR_BYTES*8-1:0] station,
    output logic                    addr_full,
    output logic                    is_match,
    output logic                    is_bcast,
    output logic                    is_group
);
    localparam int IDX_W = $clog2(ADDR_BYTES + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ADDR_BYTES);

    logic [IDX_W-1:0] idx;
    logic             eq_r, ff_r, grp_r;
    logic [7:0]       ref_byte;

    always_comb begin
        ref_byte = 8'h00;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == IDX_W'(k)) ref_byte = station[(ADDR_BYTES-1-k)*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            eq_r  <= 1'b1;
            ff_r  <= 1'b1;
            grp_r <= 1'b0;
        end else if (clear) begin
            idx   <= '0;
            eq_r  <= 1'b1;
            ff_r  <= 1'b1;
            grp_r <= 1'b0;
        end else if (byte_en && idx != LAST) begin
            idx  <= idx + 1'b1;
            eq_r <= eq_r & (byte_data == ref_byte);
            ff_r <= ff_r & (byte_data == 8'hFF);
            if (idx == '0) grp_r <= byte_data[0];
        end
    end

    assign addr_full = (idx == LAST);
    assign is_match  = addr_full & eq_r;
    assign is_bcast  = addr_full & ff_r;
    assign is_group  = grp_r;

    assert_idx_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST);
    assert_bcast_is_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_bcast |-> is_group);
endmodule

// File: rtl/rxf_len_track.sv
module rxf_len_track #(
    parameter int CNT_W   = 11,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int HDR     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             byte_en,
    output logic [CNT_W-1:0] offset,
    output logic             range_err
);
    localparam logic [CNT_W-1:0] CAP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (clear)                 cnt <= '0;
        else if (byte_en && cnt != CAP) cnt <= cnt + 1'b1;
    end

    assign sum       = {1'b0, cnt} + (CNT_W+1)'(HDR);
    assign offset    = sum[CNT_W] ? CAP : sum[CNT_W-1:0];
    assign range_err = (cnt < CNT_W'(MIN_LEN)) || (cnt > CNT_W'(MAX_LEN));

    assert_cnt_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> cnt >= $past(cnt));
endmodule

// File: rtl/rxf_accept_decode.sv
module rxf_accept_decode #(
    parameter int MODE_W = 4
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              is_match,
    input  logic              is_group,
    input  logic              is_bcast,
    input  logic              range_err,
    input  logic              crc_err,
    input  logic              frame_err,
    output logic              keep
);
    logic [MODE_W-1:0] cls;
    logic [MODE_W-1:0] sub;
    logic              addr_ok, err_ok;

    always_comb begin
        cls = mode / MODE_W'(3);
        sub = mode % MODE_W'(3);
        unique case (cls)
            MODE_W'(0): addr_ok = 1'b1;
            MODE_W'(1): addr_ok = is_match | is_group;
            MODE_W'(2): addr_ok = is_match | is_bcast;
            default:    addr_ok = 1'b0;
        endcase
        unique case (sub)
            MODE_W'(0): err_ok = 1'b1;
            MODE_W'(1): err_ok = !(range_err | crc_err | frame_err);
            default:    err_ok = !(crc_err | frame_err);
        endcase
        keep = addr_ok & err_ok;
    end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int MODE_W     = 4,
    parameter int CNT_W      = 11,
    parameter int MIN_LEN    = 64,
    parameter int MAX_LEN    = 1518,
    parameter int HDR        = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic [MODE_W-1:0]       accept_mode,
    input  logic                    frame_start,
    input  logic                    byte_valid,
    input  logic [7:0]              byte_data,
    input  logic                    frame_end,
    input  logic [2:0]              extra_bits,
    input  logic                    fcs_bad,
    output logic                    done,
    output logic                    keep,
    output logic [15:0]             status
);
    import rxf_pkg::*;

    rxf_state_t  state, state_nx;
    rxf_status_t stat_nx, stat_r;
    logic        keep_nx, keep_r;
    logic        in_frame, byte_en;
    logic        addr_full, is_match, is_bcast, is_group;
    logic        range_err, frame_err;
    logic [CNT_W-1:0] offset;

    assign in_frame = (state == S_ADDR) || (state == S_BODY);
    assign byte_en  = byte_valid && in_frame && !frame_start;

    rxf_addr_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
        .clk(clk), .rst_n(rst_n), .clear(frame_start), .byte_en(byte_en),
        .byte_data(byte_data), .station(station_addr), .addr_full(addr_full),
        .is_match(is_match), .is_bcast(is_bcast), .is_group(is_group)
    );

    rxf_len_track #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .HDR(HDR)) u_len (
        .clk(clk), .rst_n(rst_n), .clear(frame_start), .byte_en(byte_en),
        .offset(offset), .range_err(range_err)
    );

    assign frame_err = (extra_bits != 3'd0);

    rxf_accept_decode #(.MODE_W(MODE_W)) u_dec (
        .mode(accept_mode), .is_match(is_match), .is_group(is_group),
        .is_bcast(is_bcast), .range_err(range_err), .crc_err(fcs_bad),
        .frame_err(frame_err), .keep(keep_nx)
    );

    always_comb begin
        stat_nx.crc_err   = fcs_bad;
        stat_nx.bcast_n   = ~is_bcast;
        stat_nx.range_err = range_err;
        stat_nx.match_n   = ~is_match;
        stat_nx.frame_err = frame_err;
        stat_nx.offset    = 11'(offset);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (frame_start) state_nx = S_ADDR;
            S_ADDR: begin
                if (frame_start)    state_nx = S_ADDR;
                else if (frame_end) state_nx = S_REPORT;
                else if (addr_full) state_nx = S_BODY;
            end
            S_BODY: begin
                if (frame_start)    state_nx = S_ADDR;
                else if (frame_end) state_nx = S_REPORT;
            end
            S_REPORT: state_nx = frame_start ? S_ADDR : S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_r <= '0;
            keep_r <= 1'b0;
        end else if (in_frame && frame_end && !frame_start) begin
            stat_r <= stat_nx;
            keep_r <= keep_nx;
        end else if (state == S_REPORT) begin
            stat_r <= '0;
            keep_r <= 1'b0;
        end
    end

    assign done   = (state == S_REPORT);
    assign keep   = keep_r;
    assign status = stat_r;

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done && !frame_start |=> !done);
    assert_keep_in_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        keep |-> done);
    assert_frame_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status[11] == ($past(extra_bits) != 3'd0));
    assert_crc_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status[15] == $past(fcs_bad));
    assert_high_modes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done && ($past(accept_mode) > MODE_W'(8)) |-> !keep);
    assert_strict_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
        keep && ($past(accept_mode) >= MODE_W'(6)) |-> !(status[12] && status[14]));
endmodule

// File: tb/rx_frame_filter_test.sv
module rx_frame_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] station_addr = 48'h02_11_22_33_44_55;
    logic [3:0]  accept_mode = 4'd0;
    logic        frame_start = 1'b0, byte_valid = 1'b0, frame_end = 1'b0, fcs_bad = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [2:0]  extra_bits = 3'd0;
    logic        done, keep;
    logic [15:0] status;

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rx_frame_filter uut (
        .clk(clk), .rst_n(rst_n), .station_addr(station_addr), .accept_mode(accept_mode),
        .frame_start(frame_start), .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_end(frame_end), .extra_bits(extra_bits), .fcs_bad(fcs_bad),
        .done(done), .keep(keep), .status(status)
    );

    // dest types: 0 own, 1 other unicast, 2 group, 3 all-ones
    // vector fields: [31:28] mode, [27:26] dest, [25:15] bytes, [14:12] extra, [11] crc, [10] keep
    localparam int NV = 20;
    localparam logic [31:0] VEC [NV] = '{
        {4'd0, 2'd1, 11'd64,   3'd0, 1'b0, 1'b1, 10'd0}, // R6
        {4'd0, 2'd1, 11'd63,   3'd0, 1'b1, 1'b1, 10'd0}, // R6 R3
        {4'd1, 2'd0, 11'd64,   3'd0, 1'b0, 1'b1, 10'd0}, // R9
        {4'd1, 2'd0, 11'd63,   3'd0, 1'b0, 1'b0, 10'd0}, // R9 R3
        {4'd1, 2'd0, 11'd100,  3'd3, 1'b0, 1'b0, 10'd0}, // R9 R4
        {4'd2, 2'd0, 11'd63,   3'd0, 1'b0, 1'b1, 10'd0}, // R9
        {4'd2, 2'd0, 11'd100,  3'd0, 1'b1, 1'b0, 10'd0}, // R9 R4
        {4'd3, 2'd2, 11'd80,   3'd0, 1'b0, 1'b1, 10'd0}, // R7
        {4'd3, 2'd3, 11'd80,   3'd0, 1'b0, 1'b1, 10'd0}, // R7 R2
        {4'd3, 2'd1, 11'd80,   3'd0, 1'b0, 1'b0, 10'd0}, // R7
        {4'd4, 2'd2, 11'd80,   3'd0, 1'b1, 1'b0, 10'd0}, // R7 R9
        {4'd5, 2'd0, 11'd1519, 3'd0, 1'b0, 1'b1, 10'd0}, // R3 R9
        {4'd6, 2'd2, 11'd80,   3'd0, 1'b0, 1'b0, 10'd0}, // R8
        {4'd6, 2'd3, 11'd80,   3'd0, 1'b0, 1'b1, 10'd0}, // R8
        {4'd7, 2'd0, 11'd1518, 3'd0, 1'b0, 1'b1, 10'd0}, // R3 R1
        {4'd7, 2'd3, 11'd1519, 3'd0, 1'b0, 1'b0, 10'd0}, // R9
        {4'd8, 2'd1, 11'd80,   3'd0, 1'b0, 1'b0, 10'd0}, // R8
        {4'd8, 2'd0, 11'd80,   3'd5, 1'b0, 1'b0, 10'd0}, // R9 R4
        {4'd9, 2'd0, 11'd80,   3'd0, 1'b0, 1'b0, 10'd0}, // R10
        {4'd0, 2'd1, 11'd5,    3'd0, 1'b0, 1'b1, 10'd0}  // R12
    };

    function automatic logic [7:0] dest_byte(input logic [1:0] dt, input int i);
        logic [47:0] a;
        case (dt)
            2'd0:    a = 48'h02_11_22_33_44_55;
            2'd1:    a = 48'h02_11_22_33_44_56;
            2'd2:    a = 48'h01_00_5E_00_00_01;
            default: a = 48'hFF_FF_FF_FF_FF_FF;
        endcase
        return a[(5-i)*8 +: 8];
    endfunction

    function automatic logic [15:0] exp_status(input logic [1:0] dt, input int n,
                                               input logic [2:0] xb, input logic crc);
        logic full;
        int   off;
        full = (n >= 6);
        off  = (n + 2 > 2047) ? 2047 : n + 2;
        return {crc, !(full && dt == 2'd3), (n < 64 || n > 1518),
                !(full && dt == 2'd0), (xb != 3'd0), 11'(off)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send(input logic [3:0] m, input logic [1:0] dt, input int n,
                        input logic [2:0] xb, input logic crc);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1;
            byte_data  = (i < 6) ? dest_byte(dt, i) : 8'(i * 7);
            @(negedge clk);
        end
        byte_valid  = 1'b0;
        accept_mode = m;
        frame_end   = 1'b1;
        extra_bits  = xb;
        fcs_bad     = crc;
        @(negedge clk);
        frame_end  = 1'b0;
        extra_bits = 3'd0;
        fcs_bad    = 1'b0;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset done",   32'(done),   32'd0);
        check("R11 reset keep",   32'(keep),   32'd0);
        check("R11 reset status", 32'(status), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            send(VEC[v][31:28], VEC[v][27:26], int'(VEC[v][25:15]), VEC[v][14:12], VEC[v][11]);
            check("R11 done pulse", 32'(done), 32'd1);
            check("R6-R10 keep (mode table)", 32'(keep), 32'(VEC[v][10]));
            check("R1 R2 R3 R4 R5 status", 32'(status),
                  32'(exp_status(VEC[v][27:26], int'(VEC[v][25:15]), VEC[v][14:12], VEC[v][11])));
            @(negedge clk);
            check("R11 done single cycle", 32'(done), 32'd0);
        end

        // R12: four matching bytes only
        send(4'd0, 2'd0, 4, 3'd0, 1'b0);
        check("R12 short frame status", 32'(status), 32'(16'h7006));
        @(negedge clk);

        // R5: offset saturation with long frame
        send(4'd0, 2'd1, 2047, 3'd0, 1'b0);
        check("R5 offset saturates", 32'(status[10:0]), 32'd2047);
        check("R3 oversize", 32'(status[13]), 32'd1);
        @(negedge clk);

        // R1: station address changed, same frame no longer matches
        station_addr = 48'h02_11_22_33_44_56;
        send(4'd6, 2'd0, 64, 3'd0, 1'b0);
        check("R1 mismatch after change", 32'(status[12]), 32'd1);
        check("R8 rejected unicast", 32'(keep), 32'd0);
        @(negedge clk);
        send(4'd6, 2'd1, 64, 3'd0, 1'b0);
        check("R1 match new station", 32'(status[12]), 32'd0);
        check("R8 accepted own", 32'(keep), 32'd1);
        @(negedge clk);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule